// File: doc/BRIEF.md
# Four-Channel DMA Bus Arbiter

This block decides which of four DMA channels owns the shared system bus. Each channel raises a request line while it has transfers pending. The arbiter asks an external bus owner for the bus. Once that owner acknowledges, the arbiter hands a one-hot grant to a single channel. The granted channel runs transfer cycles, and the end of each cycle is marked by a one-cycle done strobe. Ownership can move to another channel only at such a boundary.

A 3-bit priority mode selects the ordering. The four fixed orders are not plain index orders. When the top bit is set, the order rotates so that the most recently served channel ranks last. A hold input selects the hand-off policy. In one setting the bus moves to another requester after every transfer cycle. In the other, the owner keeps the bus until its request line falls. Rotation combined with hold gives batch service. The channels that request when the bus is first taken form a round. A late channel that ranks above the current owner is held back until that round finishes.

Configuration is captured only while no channel owns the bus. This means a mode change never reorders a service sequence that is already running. Address generation and data movement belong to the channels themselves.

Top module: `dma_bus_arbiter`

## Requirements
- R1: After reset, no channel is granted, the latched mode is fixed order code 00 with switch-per-cycle, and the rotation pointer is at channel 0.
- R2: `bus_req` is high whenever any request bit is set or a channel currently owns the bus, and low otherwise.
- R3: `chan_gnt` is one-hot or zero. Bit i grants channel i. A grant is visible only while `bus_ack` is high. An idle arbiter takes the bus only in a cycle where `bus_ack` is high and some channel requests.
- R4: With `prio_mode[2]`=0, `prio_mode[1:0]` selects the order, listed highest first: 00 gives 0,1,2,3; 01 gives 2,3,0,1; 10 gives 0,2,1,3; 11 gives 1,3,0,2.
- R5: With `prio_mode[2]`=1, the low two bits have no effect. The order starts at the channel after the one most recently granted and wraps upward (3 is followed by 0).
- R6: While a channel owns the bus, the owner changes only on a clock edge where `cyc_done` is high.
- R7: With `hold_until_empty`=0, at the end of a cycle the bus goes to the best-ranked requester other than the owner. If no other channel requests, the owner keeps the bus while it still requests. Otherwise the bus is released.
- R8: With `hold_until_empty`=1 in a fixed order, the owner keeps the bus across cycle ends while its request is high. When the request drops, the best-ranked remaining requester takes the bus, or the bus is released if there is none.
- R9: With `prio_mode[2]`=1 and `hold_until_empty`=1, the requesters present when the bus is taken form a round. The round is served in rotation order, measured from the pointer value at the start of the round.
- R10: During a round, a new requester that ranks below the current owner joins the round. A new requester that ranks above the owner waits until the round ends.
- R11: When the last round member finishes, a new round starts at once if any channel requests. Otherwise the bus is released and `bus_req` falls.
- R12: Changes on `prio_mode` or `hold_until_empty` while a channel owns the bus have no effect until the bus is idle again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_req | input | 4 | Per-channel request, bit i for channel i |
| cyc_done | input | 1 | High in the last clock of a transfer cycle |
| bus_ack | input | 1 | Bus granted to this block by the external owner |
| prio_mode | input | 3 | Bit 2 selects rotation; bits 1:0 select the fixed order |
| hold_until_empty | input | 1 | 1: owner keeps bus until its request falls |
| chan_gnt | output | 4 | One-hot channel grant |
| bus_req | output | 1 | Request for the bus toward the external owner |

## Verification
The bench aims first at the four fixed orders. A design that decoded them as index order, or swapped two codes, would grant the wrong first channel when all four request. It then checks hand-off at cycle boundaries. A switch-per-cycle design that re-picked the owner itself, or a hold design that let go early, shows up as a wrong grant right after `cyc_done`. Config changes made while busy must not reorder the next hand-off, and a late-latched mode would pick channel 2 where channel 1 is due. Long random runs across every mode, with a flickering acknowledge, are compared cycle by cycle against a reference built from priority lists. Those runs catch a pointer that does not wrap, joins that let a higher-ranked latecomer jump ahead within a round, and a bus that is not released when requests drain.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // channel count is fixed by the four priority orders below
  localparam int ARB_NCH = 4;
  localparam int ARB_CW  = $clog2(ARB_NCH);

  typedef logic [ARB_CW-1:0] ch_idx_t;

  typedef struct packed {
    logic       rotate;
    logic [1:0] order_code;
    logic       hold;
  } arb_cfg_t;

  // rank 0 is the highest priority
  function automatic ch_idx_t fixed_rank(input logic [1:0] code, input ch_idx_t ch);
    case (code)
      2'b00:   return ch;                   // 0 1 2 3
      2'b01:   return ch ^ 2'b10;           // 2 3 0 1
      2'b10:   return {ch[0], ch[1]};       // 0 2 1 3
      default: return {~ch[0], ch[1]};      // 1 3 0 2
    endcase
  endfunction

  function automatic ch_idx_t rot_rank(input ch_idx_t ch, input ch_idx_t base);
    return ch - base;
  endfunction

  function automatic ch_idx_t rank_of(input logic rotate, input logic [1:0] code,
                                      input ch_idx_t base, input ch_idx_t ch);
    return rotate ? rot_rank(ch, base) : fixed_rank(code, ch);
  endfunction

  function automatic ch_idx_t onehot_idx(input logic [ARB_NCH-1:0] v);
    ch_idx_t r;
    r = '0;
    for (int i = 0; i < ARB_NCH; i++)
      if (v[i]) r = ch_idx_t'(i);
    return r;
  endfunction

endpackage

// File: rtl/arb_cfg_latch.sv
module arb_cfg_latch
  import dma_arb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [2:0] mode_in,
  input  logic       hold_in,
  output arb_cfg_t   cfg_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cfg_q <= '0;
    else if (load)
      cfg_q <= '{rotate: mode_in[2], order_code: mode_in[1:0], hold: hold_in};
  end

endmodule

// File: rtl/arb_pick.sv
module arb_pick
  import dma_arb_pkg::*;
#(
  parameter int NCH = ARB_NCH
) (
  input  logic [NCH-1:0] mask,
  input  logic           rotate,
  input  logic [1:0]     code,
  input  ch_idx_t        base,
  output logic [NCH-1:0] win,
  output logic           any
);

  ch_idx_t rk [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_rank
    assign rk[c] = rank_of(rotate, code, base, ch_idx_t'(c));
  end

  // a channel wins when no other masked channel has a smaller rank
  always_comb begin
    win = '0;
    for (int c = 0; c < NCH; c++) begin
      win[c] = mask[c];
      for (int d = 0; d < NCH; d++)
        if (d != c && mask[d] && (rk[d] < rk[c])) win[c] = 1'b0;
    end
  end

  assign any = |mask;

  always_comb begin
    if (|mask) begin
      AST_PICK_SINGLE: assert ($onehot(win)); // R3
    end
  end

endmodule

// File: rtl/arb_round_track.sv
module arb_round_track
  import dma_arb_pkg::*;
#(
  parameter int NCH = ARB_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           enable,
  input  logic           busy,
  input  logic           ev_start,
  input  logic           ev_handoff,
  input  logic [NCH-1:0] owner,
  input  logic [NCH-1:0] req,
  input  ch_idx_t        rot_ptr,
  output logic [NCH-1:0] left,
  output ch_idx_t        base_q
);

  logic [NCH-1:0] round_q, round_n, join_v;
  ch_idx_t        base_n, own_idx, own_rank;
  logic           left_any;

  assign own_idx  = onehot_idx(owner);
  assign own_rank = rot_rank(own_idx, base_q);

  // late requesters ranked below the owner join; those above wait
  for (genvar c = 0; c < NCH; c++) begin : g_join
    assign join_v[c] = busy & req[c] & ~round_q[c] & ~owner[c]
                     & (rot_rank(ch_idx_t'(c), base_q) > own_rank);
  end

  assign left     = (round_q | join_v) & ~owner & req;
  assign left_any = |left;

  always_comb begin
    round_n = round_q;
    base_n  = base_q;
    if (!enable) begin
      round_n = '0;
    end else if (ev_start) begin
      round_n = req;
      base_n  = rot_ptr;
    end else if (ev_handoff) begin
      if (left_any) begin
        round_n = left;
      end else begin
        round_n = req;
        base_n  = rot_ptr;
      end
    end else if (busy) begin
      round_n = round_q | join_v;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      round_q <= '0;
      base_q  <= '0;
    end else begin
      round_q <= round_n;
      base_q  <= base_n;
    end
  end

  AST_OWNER_IN_ROUND: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && |owner) |-> |(owner & round_q)); // R9

endmodule

// File: rtl/dma_bus_arbiter.sv
module dma_bus_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = ARB_NCH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] chan_req,
  input  logic           cyc_done,
  input  logic           bus_ack,
  input  logic [2:0]     prio_mode,
  input  logic           hold_until_empty,
  output logic [NCH-1:0] chan_gnt,
  output logic           bus_req
);

  arb_cfg_t       cfg_q;
  logic [NCH-1:0] owner_q, owner_n;
  ch_idx_t        rot_ptr_q;

  // named events
  logic busy, ev_start, ev_done, own_req, ev_handoff, round_mode, cfg_load;

  logic [NCH-1:0] pk_req_win, pk_oth_win, pk_rnd_win, rnd_left;
  logic           pk_req_any, pk_oth_any, pk_rnd_any;
  ch_idx_t        rnd_base;

  assign busy       = |owner_q;
  assign ev_start   = ~busy & bus_ack & (|chan_req);
  assign ev_done    = busy & cyc_done;
  assign own_req    = |(owner_q & chan_req);
  assign ev_handoff = ev_done & ~own_req;
  assign round_mode = cfg_q.rotate & cfg_q.hold;
  assign cfg_load   = ~busy & ~ev_start;

  arb_cfg_latch u_cfg (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (cfg_load),
    .mode_in (prio_mode),
    .hold_in (hold_until_empty),
    .cfg_q   (cfg_q)
  );

  arb_pick #(.NCH(NCH)) u_pick_req (
    .mask   (chan_req),
    .rotate (cfg_q.rotate),
    .code   (cfg_q.order_code),
    .base   (rot_ptr_q),
    .win    (pk_req_win),
    .any    (pk_req_any)
  );

  arb_pick #(.NCH(NCH)) u_pick_oth (
    .mask   (chan_req & ~owner_q),
    .rotate (cfg_q.rotate),
    .code   (cfg_q.order_code),
    .base   (rot_ptr_q),
    .win    (pk_oth_win),
    .any    (pk_oth_any)
  );

  arb_round_track #(.NCH(NCH)) u_round (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (round_mode),
    .busy       (busy),
    .ev_start   (ev_start),
    .ev_handoff (ev_handoff),
    .owner      (owner_q),
    .req        (chan_req),
    .rot_ptr    (rot_ptr_q),
    .left       (rnd_left),
    .base_q     (rnd_base)
  );

  arb_pick #(.NCH(NCH)) u_pick_rnd (
    .mask   (rnd_left),
    .rotate (1'b1),
    .code   (cfg_q.order_code),
    .base   (rnd_base),
    .win    (pk_rnd_win),
    .any    (pk_rnd_any)
  );

  always_comb begin
    owner_n = owner_q;
    if (!busy) begin
      if (ev_start) owner_n = pk_req_win;
    end else if (ev_done) begin
      if (round_mode) begin
        if (!own_req) owner_n = pk_rnd_any ? pk_rnd_win : pk_req_win;
      end else if (cfg_q.hold) begin
        if (!own_req) owner_n = pk_req_any ? pk_req_win : '0;
      end else begin
        owner_n = pk_oth_any ? pk_oth_win : (own_req ? owner_q : '0);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      owner_q   <= '0;
      rot_ptr_q <= '0;
    end else begin
      owner_q <= owner_n;
      if (|owner_n) rot_ptr_q <= onehot_idx(owner_n) + ch_idx_t'(1);
    end
  end

  assign chan_gnt = owner_q & {NCH{bus_ack}};
  assign bus_req  = (|chan_req) | busy;

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(chan_gnt)); // R3

  AST_START_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!busy) && busy) |-> $past(bus_ack && (|chan_req))); // R3

  AST_SWITCH_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && (owner_q != $past(owner_q))) |-> $past(cyc_done)); // R6

  AST_HOLD_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy && cfg_q.hold && own_req) |-> (owner_q == $past(owner_q))); // R8

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(busy) |-> $stable(cfg_q)); // R12

endmodule

// File: tb/dma_bus_arbiter_test.sv
`timescale 1ns/1ps
module dma_bus_arbiter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] chan_req = '0;
  logic       cyc_done = 1'b0;
  logic       bus_ack = 1'b0;
  logic [2:0] prio_mode = '0;
  logic       hold_until_empty = 1'b0;
  logic [3:0] chan_gnt;
  logic       bus_req;

  int n_checks = 0;
  int n_err = 0;

  always #2.5 clk = ~clk;

  dma_bus_arbiter uut (
    .clk(clk), .rst_n(rst_n), .chan_req(chan_req), .cyc_done(cyc_done),
    .bus_ack(bus_ack), .prio_mode(prio_mode), .hold_until_empty(hold_until_empty),
    .chan_gnt(chan_gnt), .bus_req(bus_req)
  );

  // reference: priority lists, highest first, per fixed code
  int ord [4][4] = '{'{0,1,2,3}, '{2,3,0,1}, '{0,2,1,3}, '{1,3,0,2}};

  int       m_own, m_ptr, m_base;
  bit       m_rot, m_hold;
  bit [1:0] m_code;
  bit [3:0] m_round;

  function automatic int m_rank(int ch, int base);
    if (m_rot) return (ch - base + 4) % 4;
    for (int p = 0; p < 4; p++) if (ord[m_code][p] == ch) return p;
    return 9;
  endfunction

  function automatic int m_best(bit [3:0] mask, int base);
    int best = -1;
    int br = 99;
    for (int ch = 0; ch < 4; ch++)
      if (mask[ch] && m_rank(ch, base) < br) begin
        br = m_rank(ch, base);
        best = ch;
      end
    return best;
  endfunction

  task automatic model_step();
    bit [3:0] r = chan_req;
    bit [3:0] jn = '0;
    bit [3:0] left, oth;
    bit rm = m_rot && m_hold;
    int w = -2;
    if (m_own < 0) begin
      if (bus_ack && r != 0) begin
        w = m_best(r, m_ptr);
        if (rm) begin m_round = r; m_base = m_ptr; end
      end
    end else begin
      if (rm)
        for (int ch = 0; ch < 4; ch++)
          if (r[ch] && !m_round[ch] && ch != m_own && m_rank(ch, m_base) > m_rank(m_own, m_base))
            jn[ch] = 1'b1;
      if (cyc_done) begin
        if (rm) begin
          if (r[m_own]) m_round |= jn;
          else begin
            left = (m_round | jn) & ~(4'b1 << m_own) & r;
            if (left != 0) begin w = m_best(left, m_base); m_round = left; end
            else if (r != 0) begin w = m_best(r, m_ptr); m_round = r; m_base = m_ptr; end
            else begin w = -1; m_round = '0; end
          end
        end else if (m_hold) begin
          if (!r[m_own]) w = (r != 0) ? m_best(r, m_ptr) : -1;
        end else begin
          oth = r & ~(4'b1 << m_own);
          if (oth != 0) w = m_best(oth, m_ptr);
          else if (!r[m_own]) w = -1;
        end
      end else if (rm) begin
        m_round |= jn;
      end
    end
    if (m_own < 0 && w == -2) begin
      m_rot = prio_mode[2]; m_code = prio_mode[1:0]; m_hold = hold_until_empty;
    end
    if (w >= 0) begin m_own = w; m_ptr = (w + 1) % 4; end
    else if (w == -1) m_own = -1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_own = -1; m_ptr = 0; m_base = 0; m_rot = 0; m_hold = 0; m_code = 0; m_round = 0;
    end else begin
      model_step();
    end
  end

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  function automatic string rtag();
    if (m_rot && m_hold) return "R9 R10 R11 R12";
    if (m_rot) return "R5 R7 R12";
    if (m_hold) return "R4 R8 R12";
    return "R4 R7 R12";
  endfunction

  task automatic compare_model();
    logic [3:0] eg;
    eg = (m_own >= 0 && bus_ack) ? (4'b1 << m_own) : 4'b0;
    chk({rtag(), " grant"}, chan_gnt, eg);
    chk("R2 bus_req", {3'b0, bus_req}, {3'b0, ((chan_req != 0) || (m_own >= 0))});
    chk("R3 one-hot", {3'b0, $onehot0(chan_gnt)}, 4'b0001);
  endtask

  task automatic step(input logic [3:0] r, input logic cd, input logic ack);
    chan_req = r; cyc_done = cd; bus_ack = ack;
    @(negedge clk);
  endtask

  task automatic reset_dut();
    @(negedge clk);
    rst_n = 1'b0; chan_req = '0; cyc_done = 0; bus_ack = 0; prio_mode = '0; hold_until_empty = 0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic set_cfg(input logic [2:0] pm, input logic h);
    prio_mode = pm; hold_until_empty = h;
    step(4'b0000, 1'b0, 1'b1);
  endtask

  task automatic report();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    void'($urandom(32'd20240611));

    // R1 reset state
    reset_dut();
    chk("R1 reset grant", chan_gnt, 4'b0000);
    chk("R1 reset bus_req", {3'b0, bus_req}, 4'b0000);
    step(4'b1111, 1'b0, 1'b1);
    chk("R1 default order code00 first grant", chan_gnt, 4'b0001);

    // R4 code 01, then R7 switch and R6 no mid-cycle change
    reset_dut(); set_cfg(3'b001, 1'b0);
    step(4'b1111, 1'b0, 1'b1);
    chk("R4 code01 first grant", chan_gnt, 4'b0100);
    step(4'b1111, 1'b1, 1'b1);
    chk("R7 switch to next requester", chan_gnt, 4'b1000);
    step(4'b1111, 1'b0, 1'b1);
    chk("R6 no change without cyc_done", chan_gnt, 4'b1000);

    // R4 code 11 and code 10
    reset_dut(); set_cfg(3'b011, 1'b0);
    step(4'b1111, 1'b0, 1'b1);
    chk("R4 code11 first grant", chan_gnt, 4'b0010);
    reset_dut(); set_cfg(3'b010, 1'b0);
    step(4'b0110, 1'b0, 1'b1);
    chk("R4 code10 ch2 over ch1", chan_gnt, 4'b0100);

    // R5 rotation with low bits set, wraps 3 -> 0
    reset_dut(); set_cfg(3'b111, 1'b0);
    step(4'b1111, 1'b0, 1'b1);
    chk("R5 rotate start", chan_gnt, 4'b0001);
    step(4'b1111, 1'b1, 1'b1);
    chk("R5 rotate step 1", chan_gnt, 4'b0010);
    step(4'b1111, 1'b1, 1'b1);
    chk("R5 rotate step 2", chan_gnt, 4'b0100);
    step(4'b1111, 1'b1, 1'b1);
    chk("R5 rotate step 3", chan_gnt, 4'b1000);
    step(4'b1111, 1'b1, 1'b1);
    chk("R5 rotate wrap", chan_gnt, 4'b0001);

    // R3 no grant without acknowledge, R2 request still raised
    reset_dut(); set_cfg(3'b000, 1'b0);
    step(4'b0100, 1'b0, 1'b0);
    chk("R3 no grant without ack", chan_gnt, 4'b0000);
    chk("R2 bus_req with pending request", {3'b0, bus_req}, 4'b0001);
    step(4'b0100, 1'b0, 1'b1);
    chk("R3 grant after ack", chan_gnt, 4'b0100);

    // R8 hold in fixed order
    reset_dut(); set_cfg(3'b000, 1'b1);
    step(4'b0011, 1'b0, 1'b1);
    chk("R8 hold first grant", chan_gnt, 4'b0001);
    step(4'b0011, 1'b1, 1'b1);
    chk("R8 owner keeps bus", chan_gnt, 4'b0001);
    step(4'b0010, 1'b1, 1'b1);
    chk("R8 hand-off after request drops", chan_gnt, 4'b0010);

    // R12 config change while busy ignored
    reset_dut(); set_cfg(3'b000, 1'b1);
    step(4'b0111, 1'b0, 1'b1);
    chk("R12 owner ch0", chan_gnt, 4'b0001);
    prio_mode = 3'b001;
    step(4'b0111, 1'b0, 1'b1);
    step(4'b0110, 1'b1, 1'b1);
    chk("R12 old order still applies", chan_gnt, 4'b0010);

    // R9 R10 R11 rounds
    reset_dut(); set_cfg(3'b100, 1'b1);
    step(4'b1010, 1'b0, 1'b1);
    chk("R9 round start ch1", chan_gnt, 4'b0010);
    step(4'b1111, 1'b0, 1'b1);
    chk("R6 round owner stable mid-cycle", chan_gnt, 4'b0010);
    step(4'b1101, 1'b1, 1'b1);
    chk("R10 late ch2 joins, ch0 waits", chan_gnt, 4'b0100);
    step(4'b1001, 1'b1, 1'b1);
    chk("R10 round member ch3 before waiting ch0", chan_gnt, 4'b1000);
    step(4'b0001, 1'b1, 1'b1);
    chk("R11 new round for waiting ch0", chan_gnt, 4'b0001);
    step(4'b0000, 1'b1, 1'b1);
    chk("R11 release grant", chan_gnt, 4'b0000);
    chk("R11 release bus_req", {3'b0, bus_req}, 4'b0000);

    // random runs over every mode
    for (int ph = 0; ph < 16; ph++) begin
      reset_dut();
      set_cfg(3'(ph % 8), (ph >= 8));
      repeat (600) begin
        compare_model();
        for (int c = 0; c < 4; c++) begin
          if (!chan_req[c]) begin
            if ($urandom % 6 == 0) chan_req[c] = 1'b1;
          end else if ($urandom % 4 == 0) begin
            chan_req[c] = 1'b0;
          end
        end
        cyc_done = ($urandom % 2) == 1;
        bus_ack = ($urandom % 12) != 0;
        if ($urandom % 40 == 0) begin
          prio_mode = 3'($urandom % 8);
          hold_until_empty = ($urandom % 2) == 1;
        end
        @(negedge clk);
      end
    end

    report();
  end

endmodule